// File: doc/BRIEF.md
# Interrupt Acknowledge Preemption Gate

This block sits in the acknowledge path of an interrupt controller's CPU interface. A separate selector presents the best pending candidate: its index, its 8-bit priority and whether it is edge or level triggered. When the CPU asks for an acknowledge of group 0 or group 1, the block decides whether the candidate may be taken. It runs two tests. The first compares the full priority against the CPU priority mask. The second compares group priorities against the running priority, and the split between group and sub-priority comes from a binary point register.

When the candidate is taken, the block marks it active and drops its pending bit if it is edge triggered. It also pushes the candidate's priority onto a stack of running priorities. Every request receives exactly one response one cycle later. The response carries either the interrupt ID or the reserved ID 1023, which means "nothing to take".

The binary point registers live inside the block. Both reset to 0. Pending bits are raised through a per-interrupt set vector, and the block owns the pending and active state.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A request whose candidate is not valid, or whose candidate's pending bit is clear, returns ID 1023 with priority 0xFF.
- R2: A candidate is refused unless its full 8-bit priority is strictly less than the priority mask. No grouping is applied to this test.
- R3: The binary point bp (0..7) selects the group mask applied to the candidate priority. bp=0 gives 0xFE, and each step up clears one more low bit, down to 0x80 at bp=6. bp=7 gives 0x00.
- R4: The mask applied to the running priority equals the group mask for bp 0..6, and is 0xFF for bp=7.
- R5: The group 0 binary point is used when the request is for group 0 (ack_grp_i=0) or when cbpr_i=1. Otherwise the group 1 binary point is used.
- R6: A candidate is taken only when its masked priority is strictly less than the masked top of the running-priority stack. Otherwise ID 1023 is returned.
- R7: On a take, the candidate's active bit is set, the stack pointer increments, and the candidate's priority becomes run_prio_o.
- R8: On a take, an edge-triggered candidate's pending bit clears, and a level-triggered candidate stays pending.
- R9: After reset, both binary points are 0, pending and active are all 0, the stack pointer is 0 and run_prio_o is 0xFF.
- R10: The stack holds 8 entries. A request that passes both tests while the pointer is 7 is refused with ID 1023, raises overflow_o with the response, and changes no state.
- R11: Every request cycle produces ack_valid_o in the next cycle, together with the ID, the priority (the candidate's priority on a take, otherwise 0xFF) and the overflow flag. No response appears without a request.
- R12: A high bit of pend_set_i sets that interrupt's pending bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_set_i | input | NUM_IRQ | Per-interrupt pending set |
| cand_valid_i | input | 1 | Candidate present |
| cand_idx_i | input | IDX_W | Candidate interrupt index |
| cand_prio_i | input | 8 | Candidate priority |
| cand_edge_i | input | 1 | Candidate is edge triggered |
| prio_mask_i | input | 8 | CPU priority mask |
| bpr_we_i | input | 2 | Write enable: bit 0 group 0 binary point, bit 1 group 1 |
| bpr_wdata_i | input | 3 | Binary point write value |
| cbpr_i | input | 1 | Use group 0 binary point for both groups |
| ack_req_i | input | 1 | Acknowledge request |
| ack_grp_i | input | 1 | Requested group (0 or 1) |
| ack_valid_o | output | 1 | Response strobe |
| ack_id_o | output | 10 | Taken ID or 1023 |
| ack_prio_o | output | 8 | Taken priority or 0xFF |
| overflow_o | output | 1 | Refused because the stack is full |
| pending_o | output | NUM_IRQ | Pending bits |
| active_o | output | NUM_IRQ | Active bits |
| run_prio_o | output | 8 | Top of running-priority stack |
| stack_ptr_o | output | PTR_W | Stack pointer |
| bpr0_o | output | 3 | Group 0 binary point |
| bpr1_o | output | 3 | Group 1 binary point |

## Verification
The bench first sends requests with no candidate and with a candidate whose pending bit is already clear. These confirm that only owned pending state can be taken. Priorities equal to and one below the mask separate the strict mask test from an inclusive one. One candidate lands in the same group as the running priority under group 1's coarse binary point but wins under group 0's fine one, which shows which binary point is selected, with and without cbpr. A binary point of 7 then shows that the all-ones running mask still lets higher priorities through. Level and edge candidates show the pending clear, and filling the stack shows the overflow refusal.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int BP_W   = 3;
  localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [BP_W-1:0]   bp_t;
  typedef enum logic { GRP0 = 1'b0, GRP1 = 1'b1 } grp_e;
endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_ack_pkg::*;
(
  input  logic  req_i,
  input  logic  cand_ok_i,
  input  prio_t prio_i,
  input  prio_t mask_i,
  input  prio_t run_prio_i,
  input  logic  grp_i,
  input  logic  cbpr_i,
  input  bp_t   bpr0_i,
  input  bp_t   bpr1_i,
  input  logic  full_i,
  output logic  grant_o,
  output logic  ovf_o
);
  bp_t   bp_sel;
  prio_t grp_mask, run_mask;
  logic  mask_ok, preempt_ok, eligible;

  always_comb begin
    bp_sel = (grp_e'(grp_i) == GRP0 || cbpr_i) ? bpr0_i : bpr1_i;
    if (bp_sel == bp_t'(BP_W'((1 << BP_W) - 1))) begin
      grp_mask = '0;
      run_mask = '1;   // no grouping left: let anything above idle in
    end else begin
      grp_mask = prio_t'({PRIO_W{1'b1}} << (bp_sel + bp_t'(1)));
      run_mask = grp_mask;
    end
    mask_ok    = prio_i < mask_i;                       // full width, no grouping
    preempt_ok = (prio_i & grp_mask) < (run_prio_i & run_mask);
    eligible   = req_i && cand_ok_i && mask_ok && preempt_ok;
    grant_o    = eligible && !full_i;
    ovf_o      = eligible && full_i;
  end
endmodule

// File: rtl/irq_run_stack.sv
module irq_run_stack
  import irq_ack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  prio_t            push_prio_i,
  output prio_t            top_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  prio_t            stk_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_nxt;

  assign ptr_nxt = ptr_q + PTR_W'(1);
  assign full_o  = ptr_q == PTR_W'(DEPTH - 1);
  assign top_o   = stk_q[ptr_q];
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               stk_q[g] <= IDLE_PRIO;
      else if (push_i && ptr_nxt == PTR_W'(g))   stk_q[g] <= push_prio_i;
    end
  end

  AST_PTR_INC:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                  push_i |=> ptr_q == $past(ptr_q) + PTR_W'(1));          // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                  !push_i |=> $stable(ptr_q));                            // R7
  AST_TOP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                  push_i |=> top_o == $past(push_prio_i));                // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
                  push_i |-> !full_o);                                    // R10
endmodule

// File: rtl/irq_state_bits.sv
module irq_state_bits #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic               ack_edge_i,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic hit;
    assign hit = ack_i && ack_idx_i == IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pending_o[g] <= 1'b0;
        active_o[g]  <= 1'b0;
      end else begin
        if (set_i[g])              pending_o[g] <= 1'b1;   // new event wins over clear
        else if (hit && ack_edge_i) pending_o[g] <= 1'b0;
        if (hit)                   active_o[g]  <= 1'b1;
      end
    end
  end

  AST_ACT_SET:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                    ack_i |=> active_o[$past(ack_idx_i)]);                           // R7
  AST_EDGE_CLR:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (ack_i && ack_edge_i && !set_i[ack_idx_i]) |=> !pending_o[$past(ack_idx_i)]); // R8
  AST_LEVEL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (ack_i && !ack_edge_i && pending_o[ack_idx_i]) |=> pending_o[$past(ack_idx_i)]); // R8
  AST_SET_PEND:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    set_i[ack_idx_i] |=> pending_o[$past(ack_idx_i)]);               // R12
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int STACK_DEPTH = 8,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int PTR_W = $clog2(STACK_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_set_i,
  input  logic               cand_valid_i,
  input  logic [IDX_W-1:0]   cand_idx_i,
  input  logic [7:0]         cand_prio_i,
  input  logic               cand_edge_i,
  input  logic [7:0]         prio_mask_i,
  input  logic [1:0]         bpr_we_i,
  input  logic [2:0]         bpr_wdata_i,
  input  logic               cbpr_i,
  input  logic               ack_req_i,
  input  logic               ack_grp_i,
  output logic               ack_valid_o,
  output logic [9:0]         ack_id_o,
  output logic [7:0]         ack_prio_o,
  output logic               overflow_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [7:0]         run_prio_o,
  output logic [PTR_W-1:0]   stack_ptr_o,
  output logic [2:0]         bpr0_o,
  output logic [2:0]         bpr1_o
);
  bp_t   bpr0_q, bpr1_q;
  prio_t run_top;
  logic  full, grant, ovf, cand_ok;
  logic [NUM_IRQ-1:0] pend_vec, act_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpr0_q <= '0;
      bpr1_q <= '0;
    end else begin
      if (bpr_we_i[0]) bpr0_q <= bpr_wdata_i;
      if (bpr_we_i[1]) bpr1_q <= bpr_wdata_i;
    end
  end

  assign cand_ok = cand_valid_i && pend_vec[cand_idx_i];

  irq_prio_gate u_gate (
    .req_i      (ack_req_i),
    .cand_ok_i  (cand_ok),
    .prio_i     (cand_prio_i),
    .mask_i     (prio_mask_i),
    .run_prio_i (run_top),
    .grp_i      (ack_grp_i),
    .cbpr_i     (cbpr_i),
    .bpr0_i     (bpr0_q),
    .bpr1_i     (bpr1_q),
    .full_i     (full),
    .grant_o    (grant),
    .ovf_o      (ovf)
  );

  irq_run_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (grant),
    .push_prio_i (cand_prio_i),
    .top_o       (run_top),
    .ptr_o       (stack_ptr_o),
    .full_o      (full)
  );

  irq_state_bits #(.NUM_IRQ(NUM_IRQ)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (pend_set_i),
    .ack_i      (grant),
    .ack_idx_i  (cand_idx_i),
    .ack_edge_i (cand_edge_i),
    .pending_o  (pend_vec),
    .active_o   (act_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o <= 1'b0;
      ack_id_o    <= NO_IRQ_ID;
      ack_prio_o  <= IDLE_PRIO;
      overflow_o  <= 1'b0;
    end else begin
      ack_valid_o <= ack_req_i;
      ack_id_o    <= grant ? ID_W'(cand_idx_i) : NO_IRQ_ID;
      ack_prio_o  <= grant ? cand_prio_i : IDLE_PRIO;
      overflow_o  <= ovf;
    end
  end

  assign pending_o  = pend_vec;
  assign active_o   = act_vec;
  assign run_prio_o = run_top;
  assign bpr0_o     = bpr0_q;
  assign bpr1_o     = bpr1_q;

  AST_RESP_ONE:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     ack_req_i |=> ack_valid_o);                                  // R11
  AST_RESP_NONE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     !ack_req_i |=> !ack_valid_o);                                // R11
  AST_MASK_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     ack_req_i |=> (ack_id_o == NO_IRQ_ID ||
                                    $past(cand_prio_i) < $past(prio_mask_i)));    // R2
  AST_IDLE_NONE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (ack_valid_o && ack_id_o == NO_IRQ_ID) |-> ack_prio_o == IDLE_PRIO); // R1
  AST_NO_CAND:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (ack_req_i && !cand_valid_i) |=> ack_id_o == NO_IRQ_ID);     // R1
  AST_OVF_REFUSE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     overflow_o |-> ack_id_o == NO_IRQ_ID);                       // R10
  AST_OVF_HOLD:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     ovf |=> $stable(stack_ptr_o));                               // R10
endmodule

// File: tb/tb_irq_ack_ctrl.sv
module tb_irq_ack_ctrl;
  import irq_ack_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ = 32;
  localparam int IDX_W = 5;
  localparam int PTR_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_IRQ-1:0] pend_set = '0;
  logic cand_valid = 0, cand_edge = 0, cbpr = 0, ack_req = 0, ack_grp = 0;
  logic [IDX_W-1:0] cand_idx = '0;
  logic [7:0] cand_prio = '0, prio_mask = 8'hFF;
  logic [1:0] bpr_we = '0;
  logic [2:0] bpr_wdata = '0;
  logic ack_valid, overflow;
  logic [9:0] ack_id;
  logic [7:0] ack_prio, run_prio;
  logic [NUM_IRQ-1:0] pending, active;
  logic [PTR_W-1:0] stack_ptr;
  logic [2:0] bpr0, bpr1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_set_i(pend_set), .cand_valid_i(cand_valid),
    .cand_idx_i(cand_idx), .cand_prio_i(cand_prio), .cand_edge_i(cand_edge),
    .prio_mask_i(prio_mask), .bpr_we_i(bpr_we), .bpr_wdata_i(bpr_wdata), .cbpr_i(cbpr),
    .ack_req_i(ack_req), .ack_grp_i(ack_grp), .ack_valid_o(ack_valid), .ack_id_o(ack_id),
    .ack_prio_o(ack_prio), .overflow_o(overflow), .pending_o(pending), .active_o(active),
    .run_prio_o(run_prio), .stack_ptr_o(stack_ptr), .bpr0_o(bpr0), .bpr1_o(bpr1)
  );

  typedef struct packed { logic [9:0] id; logic [7:0] prio; logic ovf; } exp_t;
  exp_t  sb_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [NUM_IRQ-1:0] m_pend = '0, m_act = '0;
  logic [7:0] m_stk [8];
  int m_ptr = 0;
  logic [2:0] m_bpr0 = 0, m_bpr1 = 0;

  function automatic logic [7:0] gmask_of(input logic [2:0] bp);
    case (bp)
      3'd0: return 8'hFE;  3'd1: return 8'hFC;
      3'd2: return 8'hF8;  3'd3: return 8'hF0;
      3'd4: return 8'hE0;  3'd5: return 8'hC0;
      3'd6: return 8'h80;  default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: at a negedge, drive one request and queue its expected response
  task automatic req_ack(string tag, logic grp, logic cb, logic vld, int idx,
                         logic [7:0] prio, logic edg, logic [7:0] mask);
    logic [2:0] bp;
    logic [7:0] gm, rm;
    logic ok, ovf, grant;
    exp_t e;
    ack_grp = grp; cbpr = cb; cand_valid = vld; cand_idx = IDX_W'(idx);
    cand_prio = prio; cand_edge = edg; prio_mask = mask;
    bp = (grp == 1'b0 || cb) ? m_bpr0 : m_bpr1;
    gm = gmask_of(bp);
    rm = (bp == 3'd7) ? 8'hFF : gm;
    ok = vld && m_pend[idx] && (prio < mask) && ((prio & gm) < (m_stk[m_ptr] & rm));
    ovf = ok && (m_ptr == 7);
    grant = ok && !ovf;
    e.id = grant ? 10'(idx) : 10'd1023;
    e.prio = grant ? prio : 8'hFF;
    e.ovf = ovf;
    sb_q.push_back(e);
    tag_q.push_back(tag);
    if (grant) begin
      m_act[idx] = 1'b1;
      if (edg) m_pend[idx] = 1'b0;
      m_ptr++;
      m_stk[m_ptr] = prio;
    end
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic pend(int idx);
    pend_set[idx] = 1'b1;
    m_pend[idx] = 1'b1;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic wr_bpr(int which, logic [2:0] v);
    bpr_we = (which == 0) ? 2'b01 : 2'b10;
    bpr_wdata = v;
    if (which == 0) m_bpr0 = v; else m_bpr1 = v;
    @(negedge clk);
    bpr_we = '0;
  endtask

  task automatic state_check(string tag);
    check({tag, " pending"}, pending, m_pend);
    check({tag, " active"}, active, m_act);
    check({tag, " stack_ptr"}, 32'(stack_ptr), 32'(m_ptr));
    check({tag, " run_prio"}, 32'(run_prio), 32'(m_stk[m_ptr]));
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    string t;
    if (rst_n && ack_valid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected response actual=%0h expected=none", ack_id);
      end else begin
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({t, " id"}, 32'(ack_id), 32'(e.id));
        check({t, " prio"}, 32'(ack_prio), 32'(e.prio));
        check({t, " overflow"}, 32'(overflow), 32'(e.ovf));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", 32'(ack_valid), 0);
    check("R9 bpr0", 32'(bpr0), 0);
    check("R9 bpr1", 32'(bpr1), 0);
    state_check("R9");

    req_ack("R1 no candidate", 1, 0, 0, 3, 8'h10, 1, 8'hFF);
    pend(5);
    check("R12 pend set", 32'(pending[5]), 1);
    req_ack("R2 equal to mask", 1, 0, 1, 5, 8'h40, 1, 8'h40);
    req_ack("R1 not pending", 1, 0, 1, 6, 8'h10, 1, 8'hFF);
    req_ack("R7 take", 1, 0, 1, 5, 8'h40, 1, 8'h41);
    state_check("R8 edge");
    req_ack("R1 cleared pending", 1, 0, 1, 5, 8'h10, 1, 8'hFF);

    pend(7);
    req_ack("R8 level take", 1, 0, 1, 7, 8'h3F, 0, 8'hFF);
    state_check("R8 level");

    wr_bpr(1, 3'd3);
    check("R5 bpr1", 32'(bpr1), 3);
    pend(9);
    req_ack("R6 same group", 1, 0, 1, 9, 8'h31, 1, 8'hFF);
    req_ack("R5 group0 bp", 0, 0, 1, 9, 8'h31, 1, 8'hFF);
    state_check("R7 push");

    wr_bpr(0, 3'd7);
    pend(10);
    req_ack("R5 group1 bp", 1, 0, 1, 10, 8'h35, 1, 8'hFF);
    req_ack("R4 common bp7", 1, 1, 1, 10, 8'h35, 1, 8'hFF);
    pend(11);
    req_ack("R3 bp7 zero mask", 0, 0, 1, 11, 8'h34, 1, 8'hFF);
    state_check("R4");

    pend(12);
    req_ack("R2 mask at bp7", 0, 0, 1, 12, 8'h20, 1, 8'h20);
    req_ack("R2 below mask", 0, 0, 1, 12, 8'h20, 1, 8'h21);
    pend(13);
    req_ack("R7 fill", 0, 0, 1, 13, 8'h10, 1, 8'hFF);
    pend(14);
    req_ack("R10 overflow", 0, 0, 1, 14, 8'h05, 1, 8'hFF);
    state_check("R10");

    repeat (3) @(negedge clk);
    check("R11 all responses", 32'(sb_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule